// File: doc/BRIEF.md
# Mode-Selectable Display Timing Generator

This block produces the raster timing for a parallel RGB panel from a single pixel clock. It walks a horizontal pixel counter and a vertical line counter through fixed region sequences and derives from them the horizontal and vertical sync strobes, a data-enable strobe and the coordinates of the pixel currently on the bus. A 3-bit resolution code chooses which preset porch and sync set is used.

The code is sampled at reset and after that only at frame boundaries, so a running frame is never cut short. One code is an alias of another preset. Two codes are illegal; they are refused and flagged. A run bit pauses the raster. While it is low, the counters freeze and all strobes sit in their idle state, so the panel sees nothing until the bit returns.

Top module: `disp_timing_gen`

## Requirements
- R1: With the built-in table, the 3-bit code picks active width, front porch, sync width and back porch for each axis. Values are given as horizontal / vertical, each as active, front porch, sync, back porch. Code 7: 800,40,1,216 / 480,10,1,35. Code 6: 640,24,1,136 / 480,18,1,27. Code 5: 480,2,1,43 / 272,2,1,12. Code 4: 480,2,1,43 / 640,4,1,8. Code 0: 400,20,1,108 / 240,2,1,20.
- R2: Code 1 produces exactly the timing of code 5.
- R3: Each line runs active, front porch, sync, back porch, and pixel x counts from 0 to the line total minus 1. Each frame runs through the same four regions in lines, and y counts from 0 to the frame total minus 1. Both sync outputs are active low. Vertical sync is low on every pixel of its sync lines.
- R4: Data-enable is 1 exactly when x is inside the active width and y is inside the active height. It is never 1 while either sync output is low.
- R5: Outputs are registered. The first rising edge after reset release presents pixel (0,0) together with its data-enable and sync levels. Each later edge presents the next pixel.
- R6: A new resolution code is adopted only on the edge that ends the last pixel of a frame. The frame in progress keeps its original totals.
- R7: If code 2 or 3 is present at a frame boundary, the current mode is kept and the error output goes to 1. It stays at 1 until reset, even after a legal code is adopted.
- R8: While the run input is 0, the counters hold, data-enable is 0, both syncs are 1, and x/y hold their last value. When the run input returns, output resumes at the next pixel, with none skipped.
- R9: Synchronous active-high reset drives data-enable to 0, both syncs to 1, x and y to 0 and the error output to 0. Reset loads the mode from the code present at that time; an illegal code at reset selects code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock; all outputs change on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 = generating, 0 = standby (raster frozen, strobes idle) |
| res_code_i | input | 3 | Resolution code |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data-enable, high on active pixels |
| pix_x_o | output | 12 | Horizontal coordinate of the presented pixel |
| pix_y_o | output | 12 | Vertical coordinate of the presented pixel |
| code_err_o | output | 1 | Sticky flag: illegal code seen at a frame boundary |

## Verification
Every output is one register stage behind the counters, so the n-th sample after reset release shows pixel index n-1 of the raster. The bench counts negative edges from reset release and compares each output at the exact sample that corresponds to the pixel it expects. The effects of a code change appear at the sample that closes the old frame: the error flag is due on that same sample, and the new totals are due from the next sample. After the run input drops, output stays frozen from the next sample onward, and the skipped pixel is due on the first sample after the input returns. Preset timing is checked with a small bench-supplied table for whole frames, and with the built-in table for the first line of every code.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int TW    = 12;
  localparam int CW    = 3;
  localparam int NCODE = 1 << CW;

  typedef logic [TW-1:0] tval_t;
  typedef logic [CW-1:0] code_t;

  typedef struct packed {
    tval_t act;
    tval_t fp;
    tval_t sw;
    tval_t bp;
  } axis_t;

  typedef struct packed {
    axis_t h;
    axis_t v;
  } mode_t;

  typedef mode_t [NCODE-1:0] table_t;

  function automatic mode_t make_mode(int ha, int hf, int hs, int hb,
                                      int va, int vf, int vs, int vb);
    mode_t m;
    m.h.act = tval_t'(ha);
    m.h.fp  = tval_t'(hf);
    m.h.sw  = tval_t'(hs);
    m.h.bp  = tval_t'(hb);
    m.v.act = tval_t'(va);
    m.v.fp  = tval_t'(vf);
    m.v.sw  = tval_t'(vs);
    m.v.bp  = tval_t'(vb);
    return m;
  endfunction

  function automatic table_t preset_table();
    table_t t;
    t    = '0;
    t[7] = make_mode(800, 40, 1, 216, 480, 10, 1, 35);
    t[6] = make_mode(640, 24, 1, 136, 480, 18, 1, 27);
    t[5] = make_mode(480,  2, 1,  43, 272,  2, 1, 12);
    t[4] = make_mode(480,  2, 1,  43, 640,  4, 1,  8);
    t[0] = make_mode(400, 20, 1, 108, 240,  2, 1, 20);
    return t;
  endfunction

  localparam table_t PRESETS = preset_table();

  function automatic logic code_legal(code_t c);
    return (c != code_t'(2)) && (c != code_t'(3));
  endfunction

  function automatic code_t code_map(code_t c);
    return (c == code_t'(1)) ? code_t'(5) : c;
  endfunction
endpackage

// File: rtl/dtg_mode_ctl.sv
module dtg_mode_ctl
  import dtg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  code_t code_i,
  input  logic  frame_end_i,
  output code_t mode_o,
  output logic  err_o
);
  code_t mode_q;
  logic  err_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= code_legal(code_i) ? code_map(code_i) : code_t'(7);
      err_q  <= 1'b0;
    end else if (frame_end_i) begin
      if (code_legal(code_i)) mode_q <= code_map(code_i);
      else                    err_q  <= 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  // R6
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !frame_end_i |=> $stable(mode_o));
  // R7
  bad_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (frame_end_i && !code_legal(code_i)) |=> ($stable(mode_o) && err_o));
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |=> err_o);
  // R2
  alias_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (frame_end_i && code_i == code_t'(1)) |=> (mode_o == code_t'(5)));
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  step_i,
  input  axis_t lim_i,
  output tval_t cnt_o,
  output logic  last_o,
  output logic  act_o,
  output logic  sync_o
);
  tval_t cnt_q;
  tval_t sync_lo, sync_hi, total;

  always_comb begin
    sync_lo = lim_i.act + lim_i.fp;
    sync_hi = sync_lo + lim_i.sw;
    total   = sync_hi + lim_i.bp;
  end

  assign last_o = (cnt_q == total - tval_t'(1));
  assign act_o  = (cnt_q < lim_i.act);
  assign sync_o = (cnt_q >= sync_lo) && (cnt_q < sync_hi);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + tval_t'(1);
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q < total);
  // R8
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(cnt_o));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter table_t TIMING = PRESETS
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          run_i,
  input  logic [2:0]    res_code_i,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic          de_o,
  output logic [TW-1:0] pix_x_o,
  output logic [TW-1:0] pix_y_o,
  output logic          code_err_o
);
  code_t mode_idx;
  mode_t cur;
  tval_t hcnt, vcnt;
  logic  h_last, h_act, h_sync;
  logic  v_last, v_act, v_sync;
  logic  frame_end;

  assign cur       = TIMING[mode_idx];
  assign frame_end = run_i & h_last & v_last;

  dtg_mode_ctl u_mode (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .code_i      (res_code_i),
    .frame_end_i (frame_end),
    .mode_o      (mode_idx),
    .err_o       (code_err_o)
  );

  dtg_axis u_hor (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_i (run_i),
    .lim_i  (cur.h),
    .cnt_o  (hcnt),
    .last_o (h_last),
    .act_o  (h_act),
    .sync_o (h_sync)
  );

  dtg_axis u_ver (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_i (run_i & h_last),
    .lim_i  (cur.v),
    .cnt_o  (vcnt),
    .last_o (v_last),
    .act_o  (v_act),
    .sync_o (v_sync)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      de_o      <= 1'b0;
      hsync_n_o <= 1'b1;
      vsync_n_o <= 1'b1;
      pix_x_o   <= '0;
      pix_y_o   <= '0;
    end else if (run_i) begin
      de_o      <= h_act & v_act;
      hsync_n_o <= ~h_sync;
      vsync_n_o <= ~v_sync;
      pix_x_o   <= hcnt;
      pix_y_o   <= vcnt;
    end else begin
      de_o      <= 1'b0;
      hsync_n_o <= 1'b1;
      vsync_n_o <= 1'b1;
    end
  end

  // R4
  de_vs_sync_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    de_o |-> (hsync_n_o && vsync_n_o));
  // R8
  standby_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> (!de_o && hsync_n_o && vsync_n_o &&
                $stable(pix_x_o) && $stable(pix_y_o)));
endmodule

// File: tb/sim_disp_timing_gen.sv
module sim_disp_timing_gen;
  import dtg_pkg::*;

  function automatic table_t small_tbl();
    table_t t;
    t    = '0;
    t[7] = make_mode(4, 2, 1, 3, 3, 1, 1, 2);
    t[6] = make_mode(3, 1, 2, 1, 2, 1, 1, 1);
    t[5] = make_mode(5, 1, 1, 2, 2, 2, 1, 1);
    t[4] = make_mode(2, 1, 1, 1, 4, 1, 1, 1);
    t[0] = make_mode(6, 1, 1, 1, 2, 1, 2, 1);
    return t;
  endfunction

  // code, h act/fp/sw/bp, v act/fp/sw/bp  (bench-chosen small table)
  localparam int VEC [6][9] = '{
    '{7, 4,2,1,3, 3,1,1,2}, '{6, 3,1,2,1, 2,1,1,1}, '{5, 5,1,1,2, 2,2,1,1},
    '{4, 2,1,1,1, 4,1,1,1}, '{0, 6,1,1,1, 2,1,2,1}, '{1, 5,1,1,2, 2,2,1,1}};
  // code, h act/fp/sw/bp for the built-in presets
  localparam int DVEC [6][5] = '{
    '{7, 800,40,1,216}, '{6, 640,24,1,136}, '{5, 480,2,1,43},
    '{4, 480,2,1,43},   '{0, 400,20,1,108}, '{1, 480,2,1,43}};

  logic clk = 1'b0, rst = 1'b1, run = 1'b1;
  logic [2:0] code = 3'd7;
  logic hs0, vs0, de0, err0, hs1, vs1, de1, err1;
  logic [TW-1:0] x0, y0, x1, y1;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  disp_timing_gen #(.TIMING(small_tbl())) u0 (
    .clk_i(clk), .rst_i(rst), .run_i(run), .res_code_i(code),
    .hsync_n_o(hs0), .vsync_n_o(vs0), .de_o(de0),
    .pix_x_o(x0), .pix_y_o(y0), .code_err_o(err0));

  disp_timing_gen u1 (
    .clk_i(clk), .rst_i(rst), .run_i(run), .res_code_i(code),
    .hsync_n_o(hs1), .vsync_n_o(vs1), .de_o(de1),
    .pix_x_o(x1), .pix_y_o(y1), .code_err_o(err1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int c);
    @(negedge clk);
    code = 3'(c);
    run  = 1'b1;
    rst  = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R9: reset state
    do_reset(7);
    rst = 1'b1;
    chk(de0 == 0 && hs0 == 1 && vs0 == 1, "R9 idle strobes", {de0, hs0, vs0}, 3);
    chk(x0 == 0 && y0 == 0 && err0 == 0, "R9 coords/err", int'(x0) + int'(y0) + err0, 0);
    rst = 1'b0;

    // R3 R4 R5 R2: whole frames on the small table
    for (int v = 0; v < 6; v++) begin
      int ht, vt, nde, nhs, nvs, fhs, fvs;
      string tg;
      tg  = (VEC[v][0] == 1) ? "R2 alias" : "R3";
      ht  = VEC[v][1] + VEC[v][2] + VEC[v][3] + VEC[v][4];
      vt  = VEC[v][5] + VEC[v][6] + VEC[v][7] + VEC[v][8];
      nde = 0; nhs = 0; nvs = 0; fhs = -1; fvs = -1;
      do_reset(VEC[v][0]);
      for (int s = 1; s <= ht * vt; s++) begin
        @(negedge clk);
        if (s == 1) chk(x0 == 0 && y0 == 0 && de0 == 1, "R5 first pixel", int'(x0), 0);
        if (de0) nde++;
        if (!hs0) begin nhs++; if (fhs < 0 && y0 == 0) fhs = int'(x0); end
        if (!vs0) begin nvs++; if (fvs < 0) fvs = int'(y0); end
        if (s == ht * vt) chk(int'(x0) == ht - 1 && int'(y0) == vt - 1, {tg, " last pixel"}, int'(x0), ht - 1);
      end
      @(negedge clk);
      chk(x0 == 0 && y0 == 0, {tg, " frame wrap"}, int'(y0), 0);
      chk(nde == VEC[v][1] * VEC[v][5], "R4 de count", nde, VEC[v][1] * VEC[v][5]);
      chk(nhs == VEC[v][3] * vt, {tg, " hsync count"}, nhs, VEC[v][3] * vt);
      chk(nvs == VEC[v][7] * ht, {tg, " vsync count"}, nvs, VEC[v][7] * ht);
      chk(fhs == VEC[v][1] + VEC[v][2], {tg, " hsync start"}, fhs, VEC[v][1] + VEC[v][2]);
      chk(fvs == VEC[v][5] + VEC[v][6], {tg, " vsync start"}, fvs, VEC[v][5] + VEC[v][6]);
    end

    // R1 R2: first line of each built-in preset
    for (int v = 0; v < 6; v++) begin
      int ht, nde, nhs, fhs;
      string tg;
      tg  = (DVEC[v][0] == 1) ? "R2 preset alias" : "R1 preset";
      ht  = DVEC[v][1] + DVEC[v][2] + DVEC[v][3] + DVEC[v][4];
      nde = 0; nhs = 0; fhs = -1;
      do_reset(DVEC[v][0]);
      for (int s = 1; s <= ht; s++) begin
        @(negedge clk);
        if (de1) nde++;
        if (!hs1) begin nhs++; if (fhs < 0) fhs = int'(x1); end
        if (s == ht) chk(int'(x1) == ht - 1, {tg, " line end"}, int'(x1), ht - 1);
      end
      @(negedge clk);
      chk(x1 == 0 && y1 == 1, {tg, " next line"}, int'(y1), 1);
      chk(nde == DVEC[v][1], {tg, " active"}, nde, DVEC[v][1]);
      chk(nhs == DVEC[v][3] && fhs == DVEC[v][1] + DVEC[v][2], {tg, " sync"}, fhs, DVEC[v][1] + DVEC[v][2]);
    end

    // R9: illegal code at reset selects code 7
    do_reset(3);
    adv(10);
    chk(x0 == 9 && y0 == 0 && err0 == 0, "R9 illegal at reset", int'(x0), 9);
    adv(1);
    chk(x0 == 0 && y0 == 1, "R9 illegal at reset wrap", int'(y0), 1);

    // R6: code change mid-frame waits for the boundary
    do_reset(7);
    adv(20); code = 3'd6;
    adv(50);
    chk(x0 == 9 && y0 == 6, "R6 old frame kept", int'(x0), 9);
    adv(1);
    chk(x0 == 0 && y0 == 0, "R6 boundary", int'(x0), 0);
    adv(34);
    chk(x0 == 6 && y0 == 4, "R6 new totals", int'(x0), 6);
    adv(1);
    chk(x0 == 0 && y0 == 0, "R6 new frame wrap", int'(y0), 0);

    // R7: illegal code refused, flag sticky (now at sample 106)
    code = 3'd2;
    adv(33);
    chk(err0 == 0, "R7 no early flag", err0, 0);
    adv(1);
    chk(err0 == 1 && x0 == 6 && y0 == 4, "R7 flag at boundary", err0, 1);
    adv(10); code = 3'd5;
    adv(25);
    chk(x0 == 6 && y0 == 4, "R7 mode kept", int'(x0), 6);
    adv(1);
    chk(x0 == 0 && y0 == 0, "R7 kept frame wrap", int'(y0), 0);
    adv(53);
    chk(x0 == 8 && y0 == 5 && err0 == 1, "R7 legal adopted, flag sticky", err0, 1);
    do_reset(7);
    chk(err0 == 0, "R9 reset clears flag", err0, 0);

    // R8: standby during hsync and during active pixels
    adv(6);
    chk(x0 == 5, "R8 setup", int'(x0), 5);
    run = 1'b0;
    adv(3);
    chk(hs0 == 1 && de0 == 0 && vs0 == 1, "R8 hsync suppressed", hs0, 1);
    chk(x0 == 5 && y0 == 0, "R8 coords held", int'(x0), 5);
    run = 1'b1;
    adv(1);
    chk(x0 == 6 && hs0 == 0, "R8 resume no skip", int'(x0), 6);
    adv(5);
    chk(x0 == 1 && y0 == 1 && de0 == 1, "R8 setup active", int'(x0), 1);
    run = 1'b0;
    adv(2);
    chk(de0 == 0 && x0 == 1, "R8 de suppressed", de0, 0);
    run = 1'b1;
    adv(1);
    chk(de0 == 1 && x0 == 2, "R8 de resumes", int'(x0), 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule